// File: doc/BRIEF.md
# Byte-to-Word Write Aligner

This block sits in front of a word-program engine for a 32-bit wide flash array. A client hands it one write request: a starting byte address, a byte count, and then a stream of payload bytes. The block packs the stream into bus-wide words on word-aligned addresses. Any byte lane that the request does not cover is filled with 0xFF, so programming that word leaves those flash cells untouched and no read-modify-write is needed.

Each packed word is offered to the program engine as an address/data pair under a valid/ready handshake. The engine then returns a pass or fail result for that word. The block keeps a running count of the payload bytes it has committed. It stops at the first word that fails, and it signals completion with a one-cycle done pulse, together with an error flag and the final byte count.

Top module: `byte_word_aligner`

## Requirements
- R1: Every word offered on the program port has its address low two bits equal to zero. The first word address is the start address with those two bits cleared, and each following word address is 4 higher.
- R2: Byte lane k of a word, at data bits [8k+7:8k], holds the payload byte whose address is the word address plus k.
- R3: With an unaligned start, the first word carries 0xFF in the lanes below the start offset, followed by as many payload bytes as fit.
- R4: Between the head and the tail, each word carries four consecutive payload bytes, with no padding.
- R5: A final partial word of 1 to 3 payload bytes carries them in its low lanes and 0xFF in its upper lanes.
- R6: A request that starts and ends inside one word produces exactly one word, with 0xFF padding below and above the payload.
- R7: A zero-length request offers no word and raises done_o on the cycle after it is accepted, with err_o low and a count of 0.
- R8: The committed count grows only by the payload bytes of words that the engine reports as passed. Padding bytes are never counted.
- R9: On a failed word, the block offers no further words and accepts no further bytes. It raises done_o with err_o high, and the count excludes the bytes of the failed word.
- R10: While a word is offered and not accepted, its address and data stay unchanged.
- R11: After reset, req_ready_o is high, and byte_ready_o, wr_valid_o, done_o, err_o and committed_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request offered |
| req_ready_o | output | 1 | Block is idle and can take a request |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Number of payload bytes |
| byte_valid_i | input | 1 | Payload byte offered |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Block takes a payload byte |
| wr_valid_o | output | 1 | Word program operation offered |
| wr_ready_i | input | 1 | Engine accepts the word |
| wr_addr_o | output | ADDR_W | Aligned word address |
| wr_data_o | output | 32 | Packed, padded word |
| rsp_valid_i | input | 1 | Engine result for the last accepted word |
| rsp_ok_i | input | 1 | Result is pass (1) or fail (0) |
| done_o | output | 1 | One-cycle pulse when the request ends |
| err_o | output | 1 | Request stopped on a failed word; held until the next request |
| committed_o | output | LEN_W | Payload bytes committed; held until the next request |

## Verification
The requests cover several shapes: aligned starts with whole-word lengths, each of the three unaligned start offsets, tails of one to three bytes, and requests that fit inside a single word. Each shape isolates one padding path: head only, tail only, both sides, or none. Failures injected on the first word and on a middle word show whether the count stops at the last passed word and whether traffic halts. A stalled handshake on alternate words shows whether the offered word stays stable while it waits.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } bwa_state_e;
endpackage

// File: rtl/bwa_word_buf.sv
module bwa_word_buf #(
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned LANE_W = $clog2(BUS_BYTES),
  localparam int unsigned DATA_W = BUS_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [7:0]        byte_i,
  output logic [DATA_W-1:0] word_o
);
  // Lanes reset to all-ones so unwritten lanes program as no-ops.
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        lane_q <= 8'hFF;
      else if (clear_i)                                   lane_q <= 8'hFF;
      else if (wr_en_i && lane_i == LANE_W'(k))           lane_q <= byte_i;
    end
    assign word_o[8*k +: 8] = lane_q;
  end
endmodule

// File: rtl/bwa_ctrl.sv
module bwa_ctrl
  import bwa_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned LANE_W = $clog2(BUS_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  committed_o,
  output logic              buf_clear_o,
  output logic              buf_wr_o,
  output logic [LANE_W-1:0] lane_o
);
  bwa_state_e        state_q;
  logic [ADDR_W-1:0] word_addr_q;
  logic [LANE_W-1:0] lane_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LANE_W:0]   pend_q;
  logic [LEN_W-1:0]  committed_q;
  logic              err_q;

  logic req_fire, byte_fire, rsp_pass;
  assign req_fire  = (state_q == ST_IDLE) && req_valid_i;
  assign byte_fire = (state_q == ST_FILL) && byte_valid_i;
  assign rsp_pass  = (state_q == ST_WAIT) && rsp_valid_i && rsp_ok_i;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign byte_ready_o = (state_q == ST_FILL);
  assign wr_valid_o   = (state_q == ST_ISSUE);
  assign done_o       = (state_q == ST_DONE);
  assign wr_addr_o    = word_addr_q;
  assign err_o        = err_q;
  assign committed_o  = committed_q;
  assign buf_clear_o  = req_fire || (rsp_pass && remain_q != '0);
  assign buf_wr_o     = byte_fire;
  assign lane_o       = lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      word_addr_q <= '0;
      lane_q      <= '0;
      remain_q    <= '0;
      pend_q      <= '0;
      committed_q <= '0;
      err_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          word_addr_q <= {req_addr_i[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          lane_q      <= req_addr_i[LANE_W-1:0];
          remain_q    <= req_len_i;
          pend_q      <= '0;
          committed_q <= '0;
          err_q       <= 1'b0;
          state_q     <= (req_len_i == '0) ? ST_DONE : ST_FILL;
        end
        ST_FILL: if (byte_valid_i) begin
          remain_q <= remain_q - 1'b1;
          pend_q   <= pend_q + 1'b1;
          lane_q   <= lane_q + 1'b1;
          if (lane_q == LANE_W'(BUS_BYTES - 1) || remain_q == LEN_W'(1))
            state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (wr_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (rsp_ok_i) begin
            committed_q <= committed_q + LEN_W'(pend_q);
            pend_q      <= '0;
            if (remain_q == '0) begin
              state_q <= ST_DONE;
            end else begin
              word_addr_q <= word_addr_q + ADDR_W'(BUS_BYTES);
              lane_q      <= '0;
              state_q     <= ST_FILL;
            end
          end else begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_addr_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> wr_addr_o[LANE_W-1:0] == '0);
  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o));
  assert_zero_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i && req_len_i == '0 |=> done_o && !err_o && committed_o == '0);
  assert_err_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o && !wr_valid_o && !byte_ready_o);
  assert_count_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && req_valid_i) |=> committed_o >= $past(committed_o));
  assert_phase_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_ready_o && wr_valid_o));
endmodule

// File: rtl/byte_word_aligner.sv
module byte_word_aligner #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BUS_BYTES = 4,
  localparam int unsigned LANE_W = $clog2(BUS_BYTES),
  localparam int unsigned DATA_W = BUS_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_ok_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LEN_W-1:0]  committed_o
);
  logic              buf_clear, buf_wr;
  logic [LANE_W-1:0] lane;

  bwa_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .byte_valid_i, .byte_ready_o,
    .wr_valid_o, .wr_ready_i, .wr_addr_o,
    .rsp_valid_i, .rsp_ok_i,
    .done_o, .err_o, .committed_o,
    .buf_clear_o (buf_clear),
    .buf_wr_o    (buf_wr),
    .lane_o      (lane)
  );

  bwa_word_buf #(.BUS_BYTES(BUS_BYTES)) u_buf (
    .clk_i, .rst_ni,
    .clear_i (buf_clear),
    .wr_en_i (buf_wr),
    .lane_i  (lane),
    .byte_i  (byte_data_i),
    .word_o  (wr_data_o)
  );

  assert_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> $stable(wr_data_o));
  assert_fresh_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i |=> wr_data_o == '1);
endmodule

// File: tb/tb_byte_word_aligner.sv
module tb_byte_word_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int NCASES = 9;
  // {addr[15:0], len[15:0], fail_word[7:0]}; fail_word 0xFF = none
  localparam logic [39:0] CASES [NCASES] = '{
    {16'h0100, 16'd8,  8'hFF},
    {16'h0101, 16'd3,  8'hFF},
    {16'h0102, 16'd7,  8'hFF},
    {16'h0200, 16'd6,  8'hFF},
    {16'h0301, 16'd2,  8'hFF},
    {16'h0403, 16'd1,  8'hFF},
    {16'h0500, 16'd12, 8'h01},
    {16'h0602, 16'd9,  8'h00},
    {16'h07FD, 16'd20, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, byte_valid = 0, wr_ready = 0, rsp_valid = 0, rsp_ok = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic [7:0]  byte_data = 0;
  logic req_ready, byte_ready, wr_valid, done, err;
  logic [31:0] wr_addr, wr_data;
  logic [15:0] committed;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_word_aligner dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr), .req_len_i(req_len),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_ready_o(byte_ready),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rsp_valid_i(rsp_valid), .rsp_ok_i(rsp_ok),
    .done_o(done), .err_o(err), .committed_o(committed)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'(i * 37 + seed * 11 + 3);
  endfunction

  function automatic logic [31:0] exp_word(input int addr, input int len, input int seed, input int w);
    logic [31:0] r;
    int base;
    base = (addr & ~3) + 4 * w;
    for (int k = 0; k < 4; k++) begin
      if (base + k >= addr && base + k < addr + len) r[8*k +: 8] = pay(seed, base + k - addr);
      else r[8*k +: 8] = 8'hFF;
    end
    return r;
  endfunction

  task automatic run_case(input int addr, input int len, input int fail, input int seed);
    int off, nwords, exp_cnt, exp_seen, exp_fed, w, bi, hold_a, hold_d, lim;
    bit exp_err, rsp_due, stalled;
    string tag;
    off = addr % 4;
    nwords = (len == 0) ? 0 : (off + len + 3) / 4;
    exp_err = fail < nwords;
    exp_seen = exp_err ? fail + 1 : nwords;
    lim = 4 * fail - off;
    exp_cnt = !exp_err ? len : (fail == 0 ? 0 : (lim < len ? lim : len));
    lim = 4 * exp_seen - off;
    exp_fed = lim < len ? lim : len;
    w = 0; bi = 0; rsp_due = 0; stalled = 0; hold_a = 0; hold_d = 0;
    check(req_ready == 1'b1, "R11 idle ready", 32'(req_ready), 32'd1);
    req_valid = 1; req_addr = 32'(addr); req_len = 16'(len);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    for (int cyc = 0; cyc < 2000 && !done; cyc++) begin
      byte_valid = 0; wr_ready = 0; rsp_valid = 0; rsp_ok = 0;
      if (rsp_due) begin
        rsp_valid = 1; rsp_ok = (w != fail); w++; rsp_due = 0;
      end else if (byte_ready) begin
        byte_valid = 1; byte_data = pay(seed, bi); bi++;
      end else if (wr_valid) begin
        if (stalled) begin
          check(wr_addr == 32'(hold_a), "R10 addr hold", wr_addr, 32'(hold_a));
          check(wr_data == 32'(hold_d), "R10 data hold", wr_data, 32'(hold_d));
        end
        if (nwords == 1) tag = "R6 single word";
        else if (w == 0 && off != 0) tag = "R3 head word";
        else if (w == nwords - 1 && (off + len) % 4 != 0) tag = "R5 tail word";
        else tag = "R4 R2 full word";
        check(wr_addr == 32'((addr & ~3) + 4 * w), "R1 word address", wr_addr, 32'((addr & ~3) + 4 * w));
        check(wr_data == exp_word(addr, len, seed, w), tag, wr_data, exp_word(addr, len, seed, w));
        if ((w % 2) == 1 && !stalled) begin
          stalled = 1; hold_a = int'(wr_addr); hold_d = int'(wr_data);
        end else begin
          stalled = 0; wr_ready = 1; rsp_due = 1;
        end
      end
      @(posedge clk); @(negedge clk);
    end
    byte_valid = 0; wr_ready = 0; rsp_valid = 0; rsp_ok = 0;
    check(done == 1'b1, "R9 done reached", 32'(done), 32'd1);
    check(err == exp_err, "R9 error flag", 32'(err), 32'(exp_err));
    check(committed == 16'(exp_cnt), "R8 committed count", 32'(committed), 32'(exp_cnt));
    check(w == exp_seen, "R9 words issued", 32'(w), 32'(exp_seen));
    check(bi == exp_fed, "R9 bytes taken", 32'(bi), 32'(exp_fed));
    @(posedge clk); @(negedge clk);
    check(done == 1'b0 && req_ready == 1'b1, "R7 done one cycle", 32'({done, req_ready}), 32'b01);
    check(committed == 16'(exp_cnt), "R8 count held", 32'(committed), 32'(exp_cnt));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(req_ready == 1'b1, "R11 reset req_ready", 32'(req_ready), 32'd1);
    check({byte_ready, wr_valid, done, err} == 4'b0, "R11 reset flags",
          32'({byte_ready, wr_valid, done, err}), 32'd0);
    check(committed == 16'd0, "R11 reset count", 32'(committed), 32'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NCASES; i++) begin
      run_case(int'(CASES[i][39:24]), int'(CASES[i][23:8]),
               (CASES[i][7:0] == 8'hFF) ? 1000 : int'(CASES[i][7:0]), i + 1);
    end

    // R7: zero-length request, done on the next cycle, no word
    req_valid = 1; req_addr = 32'h0000_0902; req_len = 16'd0;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(done == 1'b1, "R7 zero length done", 32'(done), 32'd1);
    check(wr_valid == 1'b0 && byte_ready == 1'b0, "R7 zero length no word",
          32'({wr_valid, byte_ready}), 32'd0);
    check(err == 1'b0 && committed == 16'd0, "R7 zero length status",
          32'({err, committed}), 32'd0);
    @(posedge clk); @(negedge clk);
    check(req_ready == 1'b1, "R7 back to idle", 32'(req_ready), 32'd1);

    // R9: after a failure the next request starts clean
    run_case(32'h0A00, 4, 1000, 20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule